// File: doc/BRIEF.md
# Two-Dimensional Block Parity Corrector

This block guards a block of `N` data words of `W` bits with a grid of odd parity bits. Each word gets a row parity bit, and each bit position gets a column parity bit taken over the whole block. In encode mode, words pass through a valid/ready stream with their row parity bit attached. After the last word, the block emits a single column parity beat.

In check mode, the block takes back the stored words and their row parity bits, followed by the column parity word. It recomputes every parity and buffers the block internally. It then locates a single-bit fault where the failing row and failing column cross. The block repairs the fault when it lies in a data bit, and reports a fault in a parity bit as corrected without touching the data. When more than one row or column fails, it flags the block as uncorrectable and passes the data through unchanged.

Top module: `bpar_corrector`

## Requirements
- R1: In encode mode (`mode`=0) every accepted word appears on the output in the same cycle, unchanged. Its `out_rpar` is the odd row parity of the word: 1 when the word holds an even number of ones, else 0. `out_col`=0 on these beats, and `in_ready` follows `out_ready`.
- R2: One cycle after the N-th encode word is accepted, the output carries one beat with `out_col`=1. This beat's `out_data` holds the odd column parity: bit b is 1 when bit b is set in an even number of the N words. `in_ready` is 0 while this beat waits. For the words 1011, 1111, 1001, 1011 the column word is 1001.
- R3: In check mode (`mode`=1) the block accepts N beats, each holding a word (`in_data`) and its row parity bit (`in_rpar`), indexed 0..N-1 in arrival order. Beat N+1 carries the column parity word in `in_data`. The first output word is valid in the cycle after that beat is accepted.
- R4: If exactly one row and exactly one column fail, the data bit at that row and column (bit 0 = LSB) is complemented on output and `out_fixed`=1.
- R5: If exactly one row fails and no column fails, all words are output unchanged and `out_fixed`=1.
- R6: If exactly one column fails and no row fails, all words are output unchanged and `out_fixed`=1.
- R7: If two or more rows or two or more columns fail, `out_bad`=1, `out_fixed`=0, and all words are output unchanged. The two flags are never both 1.
- R8: A block whose parity is entirely consistent is output unchanged with `out_fixed`=0 and `out_bad`=0. Both flags are 0 outside the check-mode output phase.
- R9: In check mode the output words leave in order 0..N-1, one per cycle where `out_ready`=1. A word is held stable while `out_ready`=0, and `in_ready` is 0 until the last word has left.
- R10: Synchronous active-high `rst` returns the block to accepting word 0 with empty parity accumulators. After reset `out_valid`=0 while `in_valid`=0, and a partially received block is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = encode, 1 = check; held stable for a whole block |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_data | input | W | Data word, or column parity word on the last check beat |
| in_rpar | input | 1 | Row parity bit of the word (check mode) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | W | Word, corrected word or column parity word |
| out_rpar | output | 1 | Row parity of the word (encode mode, else 0) |
| out_col | output | 1 | Beat carries the column parity word |
| out_fixed | output | 1 | Block held one fault that was located and handled |
| out_bad | output | 1 | Block held more faults than can be located |

## Verification
Encode words and their row parity are combinational, so the bench checks them a quarter period after driving the word and before the edge that accepts it. The column beat is registered and is checked at the falling edge after the last word's accepting edge. In check mode, the first corrected word and both flags are due one edge after the column word is accepted. Each later word is due one edge after the previous one is taken. The bench holds `out_ready` low over one falling edge to confirm the held word does not move.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    typedef enum logic [1:0] {
        ST_TAKE  = 2'd0,
        ST_COLW  = 2'd1,
        ST_DRAIN = 2'd2
    } bpar_state_e;

    typedef struct packed {
        logic fix_data;
        logic fixed;
        logic bad;
    } bpar_verdict_t;

    // ones count saturated at 2: 0, 1 or "many"
    function automatic logic [1:0] ones_sat(input logic [63:0] v);
        logic [1:0] n;
        n = 2'd0;
        for (int i = 0; i < 64; i++) begin
            if (v[i] && n != 2'd2) n = n + 2'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/bpar_rowbuf.sv
module bpar_rowbuf #(
    parameter int W  = 4,
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          wr_rpar,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic          rd_rmis,
    output logic [N-1:0]  rmis_vec
);
    logic [W-1:0] word_q [N];

    for (genvar r = 0; r < N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[r]   <= '0;
                rmis_vec[r] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(r)) begin
                word_q[r]   <= wr_data;
                // odd parity holds when data ones + parity bit is odd
                rmis_vec[r] <= ~(^wr_data ^ wr_rpar);
            end
        end
    end

    assign rd_data = word_q[rd_idx];
    assign rd_rmis = rmis_vec[rd_idx];

    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < N));

endmodule

// File: rtl/bpar_locator.sv
module bpar_locator
    import bpar_pkg::*;
#(
    parameter int W = 4,
    parameter int N = 4
) (
    input  logic [N-1:0] rmis,
    input  logic [W-1:0] cmis,
    output bpar_verdict_t verdict
);
    logic [1:0] rows_bad;
    logic [1:0] cols_bad;

    always_comb begin
        rows_bad = ones_sat(64'(rmis));
        cols_bad = ones_sat(64'(cmis));
        verdict  = '0;
        if (rows_bad == 2'd2 || cols_bad == 2'd2) begin
            verdict.bad = 1'b1;
        end else if (rows_bad == 2'd1 && cols_bad == 2'd1) begin
            verdict.fix_data = 1'b1;
            verdict.fixed    = 1'b1;
        end else if (rows_bad != cols_bad) begin
            // lone fault sits in a parity bit: data is already right
            verdict.fixed = 1'b1;
        end
    end

    always_comb begin
        assert_flags_exclusive_R7: assert (!(verdict.fixed && verdict.bad));
    end

endmodule

// File: rtl/bpar_corrector.sv
module bpar_corrector
    import bpar_pkg::*;
#(
    parameter int W = 4,
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_rpar,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         out_rpar,
    output logic         out_col,
    output logic         out_fixed,
    output logic         out_bad
);
    bpar_state_e   state;
    logic [CW-1:0] cnt;
    logic [IW-1:0] ocnt;
    logic [W-1:0]  col_acc;
    logic [W-1:0]  cmis_q;
    logic          fire;
    logic          buf_wr;
    logic [W-1:0]  rd_data;
    logic          rd_rmis;
    logic [N-1:0]  rmis_vec;
    bpar_verdict_t verdict;

    assign in_ready = (state == ST_TAKE) && (mode || out_ready);
    assign fire     = in_valid && in_ready;
    assign buf_wr   = fire && mode && (cnt != CW'(N));

    bpar_rowbuf #(.W(W), .N(N)) u_rowbuf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (buf_wr),
        .wr_idx   (cnt[IW-1:0]),
        .wr_data  (in_data),
        .wr_rpar  (in_rpar),
        .rd_idx   (ocnt),
        .rd_data  (rd_data),
        .rd_rmis  (rd_rmis),
        .rmis_vec (rmis_vec)
    );

    bpar_locator #(.W(W), .N(N)) u_locator (
        .rmis    (rmis_vec),
        .cmis    (cmis_q),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_TAKE;
            cnt     <= '0;
            ocnt    <= '0;
            col_acc <= '0;
            cmis_q  <= '0;
        end else begin
            unique case (state)
                ST_TAKE: if (fire) begin
                    if (!mode) begin
                        col_acc <= col_acc ^ in_data;
                        if (cnt == CW'(N - 1)) begin
                            cnt   <= '0;
                            state <= ST_COLW;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end else if (cnt != CW'(N)) begin
                        col_acc <= col_acc ^ in_data;
                        cnt     <= cnt + CW'(1);
                    end else begin
                        cmis_q  <= ~(col_acc ^ in_data);
                        col_acc <= '0;
                        cnt     <= '0;
                        ocnt    <= '0;
                        state   <= ST_DRAIN;
                    end
                end
                ST_COLW: if (out_ready) begin
                    col_acc <= '0;
                    state   <= ST_TAKE;
                end
                ST_DRAIN: if (out_ready) begin
                    if (ocnt == IW'(N - 1)) begin
                        ocnt  <= '0;
                        state <= ST_TAKE;
                    end else begin
                        ocnt <= ocnt + IW'(1);
                    end
                end
                default: state <= ST_TAKE;
            endcase
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_rpar  = 1'b0;
        out_col   = 1'b0;
        out_fixed = 1'b0;
        out_bad   = 1'b0;
        unique case (state)
            ST_TAKE: if (!mode) begin
                out_valid = in_valid;
                out_data  = in_data;
                out_rpar  = ~^in_data;
            end
            ST_COLW: begin
                out_valid = 1'b1;
                out_data  = ~col_acc;
                out_col   = 1'b1;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_data  = rd_data ^ ((verdict.fix_data && rd_rmis) ? cmis_q : '0);
                out_fixed = verdict.fixed;
                out_bad   = verdict.bad;
            end
            default: ;
        endcase
    end

    assert_colbeat_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAKE && !mode && fire && cnt == CW'(N - 1)) |=> (out_valid && out_col && !in_ready));

    assert_drain_starts_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAKE && mode && fire && cnt == CW'(N)) |=> (out_valid && !out_col));

    assert_drain_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && !out_ready) |=> (out_valid && $stable(out_data) && $stable(ocnt)));

    assert_flag_scope_R8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_DRAIN) |-> (!out_fixed && !out_bad));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (state == ST_TAKE && cnt == '0 && col_acc == '0));

endmodule

// File: tb/test_bpar_corrector.sv
`timescale 1ns/1ps
module test_bpar_corrector;
    localparam int W = 4;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         mode;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_data;
    logic         in_rpar;
    logic         out_valid;
    logic         out_ready;
    logic [W-1:0] out_data;
    logic         out_rpar;
    logic         out_col;
    logic         out_fixed;
    logic         out_bad;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bpar_corrector #(.W(W), .N(N)) i_bpar_corrector (
        .clk(clk), .rst(rst), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_rpar(in_rpar),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_rpar(out_rpar), .out_col(out_col), .out_fixed(out_fixed), .out_bad(out_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic odd_of(input logic [W-1:0] v);
        int n = 0;
        for (int b = 0; b < W; b++) n += int'(v[b]);
        return (n % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    function automatic logic [W-1:0] word_gen(input int seed, input int i);
        return W'((seed * 7 + i * 5 + 3 + seed * i) % (1 << W));
    endfunction

    // encode one block, checking R1 and R2
    task automatic encode_block(input logic [W-1:0] w [N]);
        logic [W-1:0] col;
        for (int b = 0; b < W; b++) begin
            int n = 0;
            for (int i = 0; i < N; i++) n += int'(w[i][b]);
            col[b] = (n % 2 == 0);
        end
        mode = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = w[i];
            #1;
            chk(out_valid && !out_col && out_data == w[i] && in_ready, "R1 pass", int'(out_data), int'(w[i]));
            chk(out_rpar == odd_of(w[i]), "R1 rpar", int'(out_rpar), int'(odd_of(w[i])));
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        chk(out_valid && out_col && !in_ready, "R2 colbeat", int'({out_valid, out_col, in_ready}), 6);
        chk(out_data == col, "R2 colword", int'(out_data), int'(col));
        @(negedge clk);
        chk(out_col && out_data == col, "R2 colheld", int'(out_data), int'(col));
        out_ready = 1'b1;
        @(posedge clk);
    endtask

    // send a check block (possibly corrupted) and verify output
    task automatic check_block(input logic [W-1:0] w [N], input logic [N-1:0] rp,
                               input logic [W-1:0] cp, input string tag);
        logic [N-1:0] rm;
        logic [W-1:0] cm;
        int rc = 0;
        int cc = 0;
        bit exp_fix;
        bit exp_bad;
        for (int i = 0; i < N; i++) begin
            rm[i] = (odd_of(w[i]) != rp[i]);
            rc += int'(rm[i]);
        end
        for (int b = 0; b < W; b++) begin
            int n = int'(cp[b]);
            for (int i = 0; i < N; i++) n += int'(w[i][b]);
            cm[b] = (n % 2 == 0);
            cc += int'(cm[b]);
        end
        exp_bad = (rc > 1) || (cc > 1);
        exp_fix = !exp_bad && (rc + cc > 0);
        mode = 1'b1;
        out_ready = 1'b1;
        for (int i = 0; i <= N; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = (i < N) ? w[i] : cp;
            in_rpar = (i < N) ? rp[i] : 1'b0;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] e;
            e = w[i];
            if (rc == 1 && cc == 1 && rm[i]) e = w[i] ^ cm;
            if (i == 0) begin
                out_ready = 1'b0;
                #1;
                chk(out_valid && !in_ready && out_data == e, {tag, " R9 stall"}, int'(out_data), int'(e));
                @(negedge clk);
            end
            out_ready = 1'b1;
            #1;
            chk(out_valid && !out_col && out_data == e, {tag, " data"}, int'(out_data), int'(e));
            chk(out_fixed == exp_fix && out_bad == exp_bad, {tag, " flags"},
                int'({out_fixed, out_bad}), int'({exp_fix, exp_bad}));
            @(negedge clk);
        end
        #1;
        chk(!out_fixed && !out_bad && in_ready, "R8 idle flags", int'({out_fixed, out_bad, in_ready}), 1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w [N];
        logic [W-1:0] c [N];
        logic [N-1:0] rp;
        logic [W-1:0] cp;
        rst = 1'b1; mode = 1'b0; in_valid = 1'b0; in_data = '0; in_rpar = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid && !out_fixed && !out_bad, "R10 reset", int'({out_valid, out_fixed, out_bad}), 0);

        // R2 worked example
        w[0] = 4'b1011; w[1] = 4'b1111; w[2] = 4'b1001; w[3] = 4'b1011;
        encode_block(w);
        for (int s = 0; s < 16; s++) begin
            for (int i = 0; i < N; i++) w[i] = word_gen(s, i);
            encode_block(w);
        end

        // R10: partial check block then reset, then a clean block
        mode = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 4'hF; in_rpar = 1'b0;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < N; i++) begin
                w[i] = word_gen(s + 3, i);
                rp[i] = odd_of(w[i]);
            end
            for (int b = 0; b < W; b++) begin
                int n = 0;
                for (int i = 0; i < N; i++) n += int'(w[i][b]);
                cp[b] = (n % 2 == 0);
            end
            check_block(w, rp, cp, s == 0 ? "R10 R8 clean" : "R8 clean");
            // R4: every single data bit
            for (int k = 0; k < N * W; k++) begin
                c = w;
                c[k / W][k % W] = ~c[k / W][k % W];
                check_block(c, rp, cp, "R4 single");
            end
            // R5: each row parity bit
            for (int r = 0; r < N; r++) check_block(w, rp ^ N'(1 << r), cp, "R5 rowpar");
            // R6: each column parity bit
            for (int b = 0; b < W; b++) check_block(w, rp, cp ^ W'(1 << b), "R6 colpar");
            // R7: every pair of data bits
            if (s < 2) begin
                for (int k = 0; k < N * W; k++) begin
                    for (int m = k + 1; m < N * W; m++) begin
                        c = w;
                        c[k / W][k % W] = ~c[k / W][k % W];
                        c[m / W][m % W] = ~c[m / W][m % W];
                        check_block(c, rp, cp, "R7 double");
                    end
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule